// File: doc/BRIEF.md
# PHY Management Frame Register with Internal PHY Model

This block gives a host a single 32-bit management frame register through which it reaches a small model of an Ethernet PHY. The host writes one frame word carrying a start code, an opcode, a PHY address, a register address, turnaround bits and a 16-bit data value. In the next cycle the block has carried out the access against its internal bank of 32 sixteen-bit PHY registers and holds the completed frame, with the completion flag set, for the host to read back. A frame with a bad start code or for another PHY address still completes, but it does no access.

The PHY model imitates the side effects that driver software expects. A reset request in the control register clears itself and turns on auto-negotiation. A negotiation restart clears itself and reports negotiation done at once. A link-up input drives the link bits, and every change of that input sets all bits of a 16-bit management status word and sends out a one-cycle event pulse for interrupt logic. A separate 32-bit configuration register has two read-only transceiver-detect bits.

Top module: `phy_mgmt_port`

## Requirements
- R1: A frame write (`wr_frame`) shows up on `frame_q` in the next cycle. Bits 31:17 are as written and bit 16, the completion flag, is 1. The frame fields are: start in bits 31:30, opcode in 29:28, PHY address in 27:23, register index in 22:18, turnaround in 17:16 and data in 15:0.
- R2: If the start field is not 01, the frame completes (bit 16 set, data bits as written) and no PHY register changes.
- R3: Only PHY address 1 is served. A frame with any other address completes with bit 16 set and changes no PHY register.
- R4: Opcode 01 stores the data field into the indexed PHY register. Opcode 10 returns that register's contents in bits 15:0 of `frame_q`. Opcodes 00 and 11 do no access and keep the written data.
- R5: A write to PHY register 0 with bit 15 (reset) set stores the value with bit 15 cleared and bit 12 (auto-negotiation enable) set.
- R6: A write to PHY register 0 with bit 9 (restart) set stores the value with bit 9 cleared and sets bit 5 (negotiation done) of register 1. If `link_up` is high, it also sets bit 2 (link) of register 1 and bit 8 (partner 100-full-duplex) of register 5.
- R7: `cfg_q` resets to 0x00000100. Host writes (`wr_cfg`) set all bits except bits 9:8, which keep their value.
- R8: Each change of `link_up` makes register 1 bit 2 and register 5 bit 8 follow the new level. In the following cycle `mgmt_stat` is 0xFFFF and `stat_evt` is high for exactly one cycle.
- R9: After reset, register 1 reads 0x4028 with bit 2 ORed in from `link_up`. Register 4 reads 0x0100. Register 5 reads 0x0100 if the link is up and 0 if not. Registers 2 and 3 read the PHY_ID1/PHY_ID2 parameters. All other registers read 0. The link level present at reset is taken in without a status event.
- R10: `stat_clr` clears `mgmt_stat` to 0. A link change in the same cycle wins and gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_frame | input | 1 | Host writes `wr_data` as a management frame |
| wr_cfg | input | 1 | Host writes `wr_data` to the configuration register |
| wr_data | input | 32 | Host write data |
| link_up | input | 1 | Current link level |
| stat_clr | input | 1 | Clear the management status word |
| frame_q | output | 32 | Completed management frame |
| cfg_q | output | 32 | Configuration register |
| mgmt_stat | output | 16 | Management status word |
| stat_evt | output | 1 | One-cycle pulse when a link change sets the status |

## Verification
The assertions check on every cycle the properties that need no model of the PHY registers. These are: the completion flag and the untouched frame header after each frame write, the frame register holding when no frame is written, the read-only configuration bits, the status word reading all ones whenever the event pulse is high, and the clear strobe. Only the bench scenarios can show what a frame actually does to the 32-entry register bank. That covers stored and returned data, malformed or foreign frames leaving the bank untouched, the self-clearing control bits and the restart side effects that depend on the link. The bench sees these by reading registers back through later frames, and it also checks the reset contents, which depend on the link level.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int FRM_W    = 32;
  localparam int DATA_W   = 16;
  localparam int REG_AW   = 5;
  localparam int NUM_REGS = 1 << REG_AW;

  // frame field positions (decoded by the frame decoder)
  localparam int ST_LSB   = 30;
  localparam int OP_LSB   = 28;
  localparam int PA_LSB   = 23;
  localparam int RA_LSB   = 18;
  localparam int DONE_BIT = 16;

  localparam logic [1:0] ST_VALID = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  // PHY register indices
  localparam int R_CTL = 0;
  localparam int R_STS = 1;
  localparam int R_ID1 = 2;
  localparam int R_ID2 = 3;
  localparam int R_ADV = 4;
  localparam int R_LPA = 5;

  // bit positions inside PHY registers
  localparam int CTL_RESET   = 15;
  localparam int CTL_AN_EN   = 12;
  localparam int CTL_RESTART = 9;
  localparam int STS_CAP_FD  = 14;
  localparam int STS_AN_DONE = 5;
  localparam int STS_AN_CAP  = 3;
  localparam int STS_LINK    = 2;
  localparam int ABL_FD100   = 8;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [REG_AW-1:0] idx;
    logic [DATA_W-1:0] data;
  } frame_req_t;

  function automatic logic [DATA_W-1:0] phy_rst_val(int idx,
                                                    logic [DATA_W-1:0] id1,
                                                    logic [DATA_W-1:0] id2);
    logic [DATA_W-1:0] v;
    v = '0;
    case (idx)
      R_STS: begin
        v[STS_CAP_FD]  = 1'b1;
        v[STS_AN_DONE] = 1'b1;
        v[STS_AN_CAP]  = 1'b1;
      end
      R_ID1:   v = id1;
      R_ID2:   v = id2;
      R_ADV:   v[ABL_FD100] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/mgmt_frame_decode.sv
module mgmt_frame_decode
  import phy_mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic [FRM_W-1:0] word,
  output frame_req_t       req
);
  logic start_ok;
  logic addr_ok;
  logic [1:0] opc;

  always_comb begin
    start_ok = (word[ST_LSB +: 2] == ST_VALID);
    addr_ok  = (word[PA_LSB +: 5] == PHY_ADDR);
    opc      = word[OP_LSB +: 2];
    req.wr   = start_ok && addr_ok && (opc == OP_WRITE);
    req.rd   = start_ok && addr_ok && (opc == OP_READ);
    req.idx  = word[RA_LSB +: REG_AW];
    req.data = word[DATA_W-1:0];
  end
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_mgmt_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID1 = 16'h7A10,
  parameter logic [DATA_W-1:0] ID2 = 16'h4C21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              link_in,
  input  logic              link_upd,
  output logic [DATA_W-1:0] rd_val
);
  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;
  logic [DATA_W-1:0] ctl_val;
  logic              restart_hit;

  // self-clearing control bits
  always_comb begin
    ctl_val = wr_val;
    if (wr_val[CTL_RESET]) begin
      ctl_val[CTL_RESET] = 1'b0;
      ctl_val[CTL_AN_EN] = 1'b1;
    end
    ctl_val[CTL_RESTART] = 1'b0;
    restart_hit = wr_en && (idx == REG_AW'(R_CTL)) && wr_val[CTL_RESTART];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    localparam logic [DATA_W-1:0] RST_V = phy_rst_val(i, ID1, ID2);
    logic [DATA_W-1:0] ent_d;
    logic [DATA_W-1:0] ent_q;
    logic              ent_en;

    always_comb begin
      ent_d  = ent_q;
      ent_en = 1'b0;
      if (wr_en && (idx == REG_AW'(i))) begin
        ent_d  = (i == R_CTL) ? ctl_val : wr_val;
        ent_en = 1'b1;
      end
      if (i == R_STS) begin
        if (restart_hit) begin
          ent_d[STS_AN_DONE] = 1'b1;
          if (link_in) ent_d[STS_LINK] = 1'b1;
          ent_en = 1'b1;
        end
        if (link_upd) begin
          ent_d[STS_LINK] = link_in;
          ent_en = 1'b1;
        end
      end
      if (i == R_LPA) begin
        if (restart_hit && link_in) begin
          ent_d[ABL_FD100] = 1'b1;
          ent_en = 1'b1;
        end
        if (link_upd) begin
          ent_d[ABL_FD100] = link_in;
          ent_en = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= RST_V;
      else if (ent_en) ent_q <= ent_d;
    end

    assign bank_q[i] = ent_q;
  end

  assign rd_val = bank_q[idx];
endmodule

// File: rtl/mgmt_cfg_reg.sv
module mgmt_cfg_reg #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RO_MASK = 32'h0000_0300,
  parameter logic [W-1:0] RST_VAL = 32'h0000_0100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb d = (wr_val & ~RO_MASK) | (q & RO_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= d;
  end
endmodule

// File: rtl/link_watch.sv
module link_watch #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_in,
  input  logic              stat_clr,
  output logic              link_upd,
  output logic [STAT_W-1:0] stat_q,
  output logic              evt_q
);
  logic              init_pend;
  logic              link_q;
  logic              chg;
  logic              lq_en;
  logic [STAT_W-1:0] stat_d;
  logic              stat_en;

  always_comb begin
    chg      = !init_pend && (link_in != link_q);
    lq_en    = init_pend || chg;
    link_upd = lq_en;
    stat_d   = stat_q;
    stat_en  = 1'b0;
    if (stat_clr) begin
      stat_d  = '0;
      stat_en = 1'b1;
    end
    if (chg) begin
      stat_d  = '1;
      stat_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_pend <= 1'b1;
      link_q    <= 1'b0;
      stat_q    <= '0;
      evt_q     <= 1'b0;
    end else begin
      if (init_pend) init_pend <= 1'b0;
      if (lq_en)     link_q    <= link_in;
      if (stat_en)   stat_q    <= stat_d;
      evt_q <= chg;
    end
  end
endmodule

// File: rtl/phy_mgmt_port.sv
module phy_mgmt_port
  import phy_mgmt_pkg::*;
#(
  parameter logic [4:0]        PHY_ADDR = 5'd1,
  parameter logic [DATA_W-1:0] PHY_ID1  = 16'h7A10,
  parameter logic [DATA_W-1:0] PHY_ID2  = 16'h4C21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_frame,
  input  logic              wr_cfg,
  input  logic [FRM_W-1:0]  wr_data,
  input  logic              link_up,
  input  logic              stat_clr,
  output logic [FRM_W-1:0]  frame_q,
  output logic [FRM_W-1:0]  cfg_q,
  output logic [DATA_W-1:0] mgmt_stat,
  output logic              stat_evt
);
  logic [1:0]        rst_sync;
  logic              core_rst_n;
  frame_req_t        req;
  logic [DATA_W-1:0] rd_val;
  logic              link_upd;
  logic [FRM_W-1:0]  frame_d;
  logic              frame_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .word (wr_data),
    .req  (req)
  );

  phy_reg_bank #(.ID1(PHY_ID1), .ID2(PHY_ID2)) u_bank (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_en    (wr_frame && req.wr),
    .idx      (req.idx),
    .wr_val   (req.data),
    .link_in  (link_up),
    .link_upd (link_upd),
    .rd_val   (rd_val)
  );

  mgmt_cfg_reg #(.W(FRM_W)) u_cfg (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .wr_en  (wr_cfg),
    .wr_val (wr_data),
    .q      (cfg_q)
  );

  link_watch #(.STAT_W(DATA_W)) u_link (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .link_in  (link_up),
    .stat_clr (stat_clr),
    .link_upd (link_upd),
    .stat_q   (mgmt_stat),
    .evt_q    (stat_evt)
  );

  always_comb begin
    frame_en = wr_frame;
    frame_d  = wr_data;
    frame_d[DONE_BIT] = 1'b1;
    if (req.rd) frame_d[DATA_W-1:0] = rd_val;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)   frame_q <= '0;
    else if (frame_en) frame_q <= frame_d;
  end
endmodule

// File: rtl/phy_mgmt_port_chk.sv
module phy_mgmt_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_frame,
  input logic        wr_cfg,
  input logic [31:0] wr_data,
  input logic        link_up,
  input logic        stat_clr,
  input logic [31:0] frame_q,
  input logic [31:0] cfg_q,
  input logic [15:0] mgmt_stat,
  input logic        stat_evt
);
  // R1
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_frame |=> frame_q[16]);

  // R1
  header_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_frame |=> frame_q[31:17] == $past(wr_data[31:17]));

  // R1
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_frame |=> $stable(frame_q));

  // R7
  cfg_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> cfg_q[9:8] == $past(cfg_q[9:8]));

  // R8
  evt_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_evt |-> mgmt_stat == 16'hFFFF);

  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (mgmt_stat == 16'h0000) || stat_evt);
endmodule

bind phy_mgmt_port phy_mgmt_port_chk u_chk (.*);

// File: tb/phy_mgmt_port_test.sv
`timescale 1ns/1ps
module phy_mgmt_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_frame;
  logic        wr_cfg;
  logic [31:0] wr_data;
  logic        link_up;
  logic        stat_clr;
  logic [31:0] frame_q;
  logic [31:0] cfg_q;
  logic [15:0] mgmt_stat;
  logic        stat_evt;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  logic [15:0] m_phy [32];
  logic [31:0] m_cfg;
  logic        m_link;

  localparam logic [15:0] ID1 = 16'h7A10;
  localparam logic [15:0] ID2 = 16'h4C21;

  always #2 clk = ~clk;

  phy_mgmt_port uut (
    .clk(clk), .rst_n(rst_n), .wr_frame(wr_frame), .wr_cfg(wr_cfg),
    .wr_data(wr_data), .link_up(link_up), .stat_clr(stat_clr),
    .frame_q(frame_q), .cfg_q(cfg_q), .mgmt_stat(mgmt_stat),
    .stat_evt(stat_evt)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [1:0] st, logic [1:0] op,
                                     logic [4:0] pa, logic [4:0] ra,
                                     logic [1:0] ta, logic [15:0] d);
    return {st, op, pa, ra, ta, d};
  endfunction

  function automatic logic [31:0] exp_frame(logic [31:0] w);
    logic [31:0] r;
    r = w | 32'h0001_0000;
    if (w[31:30] == 2'b01 && w[27:23] == 5'd1 && w[29:28] == 2'b10)
      r[15:0] = m_phy[w[22:18]];
    return r;
  endfunction

  task automatic model_apply(logic [31:0] w);
    logic [15:0] v;
    if (w[31:30] == 2'b01 && w[27:23] == 5'd1 && w[29:28] == 2'b01) begin
      v = w[15:0];
      if (w[22:18] == 5'd0) begin
        if (v[15]) begin v[15] = 1'b0; v[12] = 1'b1; end
        if (v[9]) begin
          v[9] = 1'b0;
          m_phy[1][5] = 1'b1;
          if (m_link) begin m_phy[1][2] = 1'b1; m_phy[5][8] = 1'b1; end
        end
      end
      m_phy[w[22:18]] = v;
    end
  endtask

  task automatic frame(string tag, logic [31:0] w);
    logic [31:0] e;
    e = exp_frame(w);
    wr_frame = 1'b1;
    wr_data  = w;
    tick();
    wr_frame = 1'b0;
    check(tag, frame_q, e);
    model_apply(w);
  endtask

  task automatic read_reg(string tag, int r);
    frame(tag, mk(2'b01, 2'b10, 5'd1, 5'(r), 2'b00, 16'h0));
  endtask

  task automatic cfg_write(logic [31:0] w);
    wr_cfg  = 1'b1;
    wr_data = w;
    tick();
    wr_cfg  = 1'b0;
    m_cfg   = (w & ~32'h300) | (m_cfg & 32'h300);
    check("R7 cfg write", cfg_q, m_cfg);
  endtask

  task automatic set_link(logic v);
    link_up = v;
    m_link  = v;
    tick();
    m_phy[1][2] = v;
    m_phy[5][8] = v;
    check("R8 event pulse", {31'd0, stat_evt}, 32'd1);
    check("R8 status all ones", {16'd0, mgmt_stat}, 32'h0000_FFFF);
    tick();
    check("R8 pulse ends", {31'd0, stat_evt}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_frame = 1'b0; wr_cfg = 1'b0; wr_data = '0;
    link_up = 1'b1; stat_clr = 1'b0;
    m_link = 1'b1;
    m_cfg  = 32'h100;
    for (int i = 0; i < 32; i++) m_phy[i] = 16'h0;
    m_phy[1] = 16'h402C; m_phy[2] = ID1; m_phy[3] = ID2;
    m_phy[4] = 16'h0100; m_phy[5] = 16'h0100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R9 reset state, link high at reset, no event for the initial level
    check("R9 frame reset", frame_q, 32'h0);
    check("R7 cfg reset", cfg_q, 32'h100);
    check("R9 no initial event", {15'd0, stat_evt, mgmt_stat}, 32'h0);
    for (int r = 0; r < 8; r++) read_reg("R9 reset contents", r);

    // R7 read-only bits
    cfg_write(32'hFFFF_FFFF);
    check("R7 ro bits", cfg_q, 32'hFFFF_FDFF);
    cfg_write(32'h0000_0000);
    check("R7 bit8 stays", cfg_q, 32'h0000_0100);

    // R4 write and read back
    frame("R4 write", mk(2'b01, 2'b01, 5'd1, 5'd7, 2'b10, 16'h1234));
    read_reg("R4 read back", 7);
    frame("R4 opcode 11 no access", mk(2'b01, 2'b11, 5'd1, 5'd7, 2'b00, 16'hBEEF));
    read_reg("R4 unchanged after opcode 11", 7);

    // R2 bad start code
    frame("R2 bad start", mk(2'b00, 2'b01, 5'd1, 5'd4, 2'b00, 16'hABCD));
    frame("R2 bad start 11", mk(2'b11, 2'b01, 5'd1, 5'd4, 2'b01, 16'h5555));
    read_reg("R2 register unchanged", 4);

    // R3 foreign PHY address
    frame("R3 other phy", mk(2'b01, 2'b01, 5'd2, 5'd4, 2'b00, 16'h9999));
    frame("R3 phy zero read", mk(2'b01, 2'b10, 5'd0, 5'd4, 2'b00, 16'h7777));
    read_reg("R3 register unchanged", 4);

    // R5 reset bit self-clears and enables auto-negotiation
    frame("R5 reset write", mk(2'b01, 2'b01, 5'd1, 5'd0, 2'b00, 16'h8000));
    read_reg("R5 control value", 0);
    check("R5 control is 0x1000", {16'd0, frame_q[15:0]}, 32'h1000);

    // R6 restart with link down then up
    set_link(1'b0);
    frame("R6 clear status", mk(2'b01, 2'b01, 5'd1, 5'd1, 2'b00, 16'h0000));
    frame("R6 restart link down", mk(2'b01, 2'b01, 5'd1, 5'd0, 2'b00, 16'h0200));
    read_reg("R6 status link down", 1);
    check("R6 status is 0x0020", {16'd0, frame_q[15:0]}, 32'h0020);
    read_reg("R6 partner link down", 5);
    read_reg("R6 control cleared", 0);
    set_link(1'b1);
    frame("R6 clear status", mk(2'b01, 2'b01, 5'd1, 5'd1, 2'b00, 16'h0000));
    frame("R6 clear partner", mk(2'b01, 2'b01, 5'd1, 5'd5, 2'b00, 16'h0000));
    frame("R6 restart link up", mk(2'b01, 2'b01, 5'd1, 5'd0, 2'b00, 16'h0200));
    read_reg("R6 status link up", 1);
    check("R6 status is 0x0024", {16'd0, frame_q[15:0]}, 32'h0024);
    read_reg("R6 partner link up", 5);

    // R8 link bits follow the input
    set_link(1'b0);
    read_reg("R8 link bit low", 1);
    read_reg("R8 partner bit low", 5);

    // R10 clear, and event priority
    stat_clr = 1'b1;
    tick();
    stat_clr = 1'b0;
    check("R10 status cleared", {16'd0, mgmt_stat}, 32'h0);
    stat_clr = 1'b1;
    link_up  = 1'b1;
    m_link   = 1'b1;
    tick();
    stat_clr = 1'b0;
    m_phy[1][2] = 1'b1;
    m_phy[5][8] = 1'b1;
    check("R10 event wins", {16'd0, mgmt_stat}, 32'h0000_FFFF);
    tick();
    check("R10 pulse ends", {31'd0, stat_evt}, 32'd0);

    // R1 R2 R3 R4 constrained random frames against the model
    for (int i = 0; i < 400; i++) begin
      logic [1:0] st;
      logic [4:0] pa;
      st = ($urandom % 8 == 0) ? 2'($urandom) : 2'b01;
      pa = ($urandom % 6 == 0) ? 5'($urandom) : 5'd1;
      frame("R1 random frame",
            mk(st, 2'($urandom), pa, 5'($urandom % 8), 2'($urandom), 16'($urandom)));
      if (i % 37 == 36) cfg_write($urandom);
      if (i % 60 == 59) set_link(~m_link);
    end
    for (int r = 0; r < 32; r++) read_reg("R4 final bank compare", r);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule